// File: doc/BRIEF.md
# Protection Region Access Checker

This block decides, for every memory access, whether it may proceed under a set of programmable protection regions. There is no address translation. The address leaves the block exactly as it came in. The block also works out which region the access fell into, whether the access is allowed, and, when it is refused, why. The decision is purely combinational from the inputs. The region descriptors and the two permission words come from a configuration bank outside the block, and the block only reads them.

Each region is a naturally aligned power-of-two window of memory. Windows may overlap, and where they do, the region with the higher index decides. The access kind selects which permission word applies. Instruction fetches use the fetch word and all data accesses use the data word. A 4-bit code per region then grants rights that depend on whether the current mode is privileged. A global enable turns the whole check off.

One cycle after a strobed access, a registered fault report is available, carrying the region index and the fault reason. The surrounding pipeline can use it to raise an abort.

Top module: `prot_region_check`

## Requirements
- R1: Region n uses descriptor bits [32n+31:32n]. Bit 0 enables the region and bits [5:1] hold a size exponent S. An enabled region covers the aligned 2^(S+1)-byte window whose upper address bits equal the descriptor's bits above bit S.
- R2: A size exponent of 31 makes the region cover the whole 4 GB address space, so every address matches it.
- R3: When several enabled regions match, the highest-numbered one decides the outcome and is reported on `hit_idx`.
- R4: With checking on and no enabled region matching, the access is refused with `fault_kind` = 1 (background fault) and `hit_idx` = 0.
- R5: The permission code of region n is bits [4n+3:4n] of a permission word. Access kind 2 (fetch) uses `perm_inst`. Kinds 0 (read), 1 (write) and 3 (treated as read) use `perm_data`.
- R6: The codes grant these rights, where `acc_priv`=1 means privileged mode. 0 grants nothing. 1 grants privileged read/write and no user rights. 2 grants privileged read/write and user read. 3 grants read/write in both modes. 5 grants privileged read only. 6 grants read in both modes. A write needs write rights, and a read or fetch needs read rights. A refused access inside a matching region gives `fault_kind` = 2 (permission fault). An allowed access gives `fault_kind` = 0.
- R7: Codes 4 and 7 to 15 grant no rights, so every access under them is refused with `fault_kind` = 2.
- R8: With `prot_on` low, every access is allowed, `fault_kind` is 0 and `hit_idx` is 0, whatever the region settings.
- R9: `addr_out` always equals `acc_addr`.
- R10: On the clock edge after a cycle with `acc_strobe` high and the access refused, `flt_valid` is 1 and `flt_region`/`flt_code` hold that cycle's `hit_idx`/`fault_kind`. After any other cycle, all three are 0.
- R11: While `rst_n` is low, `flt_valid`, `flt_region` and `flt_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_on | input | 1 | Global enable of the protection check |
| acc_strobe | input | 1 | Marks a cycle holding a real access |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_priv | input | 1 | 1 when the access runs in privileged mode |
| rgn_cfg | input | 256 | Eight region descriptors, region n at [32n+31:32n] |
| perm_data | input | 32 | Data permission codes, region n at [4n+3:4n] |
| perm_inst | input | 32 | Fetch permission codes, region n at [4n+3:4n] |
| addr_out | output | 32 | Address passed through unchanged |
| acc_ok | output | 1 | Access allowed |
| fault_kind | output | 2 | 0 none, 1 background, 2 permission |
| hit_idx | output | 3 | Index of the deciding region |
| flt_valid | output | 1 | Registered fault report |
| flt_region | output | 3 | Region of the reported fault |
| flt_code | output | 2 | Kind of the reported fault |

## Verification
A single region map is walked with addresses chosen to lie inside overlapping windows, exactly on their first and last bytes, and one byte past them. This separates the priority order from mask errors off by one bit. Each region is then probed in the read, write and fetch kinds from both privilege levels, which tells apart a swapped permission word, a wrong nibble, and a user/privileged mix-up for every code, including the undefined ones. Directed cases then clear the whole-space region to expose background faults, drop the global enable, and strobe faulting, passing and unstrobed accesses to pin the one-cycle fault report.

// File: rtl/prc_pkg.sv
package prc_pkg;
   localparam int CFG_W    = 32;
   localparam int SIZE_LSB = 1;
   localparam int SIZE_W   = 5;
   localparam int PERM_W   = 4;

   typedef enum logic [1:0] {
      ACC_RD     = 2'd0,
      ACC_WR     = 2'd1,
      ACC_FETCH  = 2'd2,
      ACC_RD_ALT = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE       = 2'd0,
      FLT_BACKGROUND = 2'd1,
      FLT_PERM       = 2'd2
   } flt_code_e;

   typedef struct packed {
      logic priv_rd;
      logic priv_wr;
      logic user_rd;
      logic user_wr;
   } rights_t;
endpackage

// File: rtl/prc_region_match.sv
module prc_region_match
   import prc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic [AW-1:0]    addr,
   output logic             hit
);
   localparam int SHW = SIZE_W + 1;

   logic [SIZE_W-1:0] size_exp;
   logic [SHW-1:0]    low_bits;
   logic [AW:0]       span;
   logic [AW-1:0]     keep_low;
   logic [AW-1:0]     diff;

   assign size_exp = cfg[SIZE_LSB +: SIZE_W];
   assign low_bits = {1'b0, size_exp} + SHW'(1);

   always_comb begin
      span = '0;
      if (int'(low_bits) >= AW) begin
         keep_low = '1;
      end else begin
         span     = (AW+1)'(1) << low_bits;
         keep_low = span[AW-1:0] - AW'(1);
      end
   end

   assign diff = cfg[AW-1:0] ^ addr;
   assign hit  = cfg[0] && ((diff & ~keep_low) == '0);
endmodule

// File: rtl/prc_prio_pick.sv
module prc_prio_pick #(
   parameter int NREG = 8,
   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic [NREG-1:0] hits,
   output logic            any_hit,
   output logic [IW-1:0]   win_idx
);
   always_comb begin
      any_hit = 1'b0;
      win_idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hits[i]) begin
            any_hit = 1'b1;
            win_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/prc_perm_eval.sv
module prc_perm_eval
   import prc_pkg::*;
(
   input  logic [PERM_W-1:0] code,
   input  logic              is_write,
   input  logic              priv,
   output logic              allow
);
   rights_t r;
   logic    may_rd;
   logic    may_wr;

   always_comb begin
      case (code)
         4'd1:    r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b0, user_wr: 1'b0};
         4'd2:    r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b0};
         4'd3:    r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b1};
         4'd5:    r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b0, user_wr: 1'b0};
         4'd6:    r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b1, user_wr: 1'b0};
         default: r = '0;
      endcase
   end

   assign may_rd = priv ? r.priv_rd : r.user_rd;
   assign may_wr = priv ? r.priv_wr : r.user_wr;
   assign allow  = is_write ? may_wr : may_rd;
endmodule

// File: rtl/prot_region_check.sv
module prot_region_check
   import prc_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 32,
   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prot_on,
   input  logic                  acc_strobe,
   input  logic [AW-1:0]         acc_addr,
   input  logic [1:0]            acc_kind,
   input  logic                  acc_priv,
   input  logic [NREG*CFG_W-1:0] rgn_cfg,
   input  logic [NREG*PERM_W-1:0] perm_data,
   input  logic [NREG*PERM_W-1:0] perm_inst,
   output logic [AW-1:0]         addr_out,
   output logic                  acc_ok,
   output logic [1:0]            fault_kind,
   output logic [IW-1:0]         hit_idx,
   output logic                  flt_valid,
   output logic [IW-1:0]         flt_region,
   output logic [1:0]            flt_code
);
   if (NREG < 1 || NREG > 16) begin : g_bad_nreg
      $error("prot_region_check: NREG must lie in 1..16");
   end
   if (AW < 8 || AW > CFG_W) begin : g_bad_aw
      $error("prot_region_check: AW must lie in 8..32");
   end

   logic [NREG-1:0]   hits;
   logic              any_hit;
   logic [IW-1:0]     win_idx;
   logic [NREG*PERM_W-1:0] perm_word;
   logic [PERM_W-1:0] perm_code;
   logic              perm_allow;
   logic              is_fetch;

   for (genvar g = 0; g < NREG; g++) begin : g_rgn
      prc_region_match #(.AW(AW)) u_match (
         .cfg  (rgn_cfg[g*CFG_W +: CFG_W]),
         .addr (acc_addr),
         .hit  (hits[g])
      );
   end

   prc_prio_pick #(.NREG(NREG)) u_pick (
      .hits    (hits),
      .any_hit (any_hit),
      .win_idx (win_idx)
   );

   assign is_fetch  = (acc_kind == ACC_FETCH);
   assign perm_word = is_fetch ? perm_inst : perm_data;
   assign perm_code = perm_word[win_idx*PERM_W +: PERM_W];

   prc_perm_eval u_perm (
      .code     (perm_code),
      .is_write (acc_kind == ACC_WR),
      .priv     (acc_priv),
      .allow    (perm_allow)
   );

   always_comb begin
      if (!prot_on) begin
         acc_ok     = 1'b1;
         fault_kind = FLT_NONE;
         hit_idx    = '0;
      end else if (!any_hit) begin
         acc_ok     = 1'b0;
         fault_kind = FLT_BACKGROUND;
         hit_idx    = '0;
      end else begin
         acc_ok     = perm_allow;
         fault_kind = perm_allow ? FLT_NONE : FLT_PERM;
         hit_idx    = win_idx;
      end
   end

   assign addr_out = acc_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_valid  <= 1'b0;
         flt_region <= '0;
         flt_code   <= FLT_NONE;
      end else if (acc_strobe && !acc_ok) begin
         flt_valid  <= 1'b1;
         flt_region <= hit_idx;
         flt_code   <= fault_kind;
      end else begin
         flt_valid  <= 1'b0;
         flt_region <= '0;
         flt_code   <= FLT_NONE;
      end
   end
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
   parameter int NREG = 8,
   parameter int AW   = 32,
   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                prot_on,
   input logic                acc_strobe,
   input logic [AW-1:0]       acc_addr,
   input logic [NREG*32-1:0]  rgn_cfg,
   input logic [AW-1:0]       addr_out,
   input logic                acc_ok,
   input logic [1:0]          fault_kind,
   input logic [IW-1:0]       hit_idx,
   input logic                flt_valid,
   input logic [IW-1:0]       flt_region,
   input logic [1:0]          flt_code
);
   logic [31:0] sel_cfg;
   assign sel_cfg = rgn_cfg[hit_idx*32 +: 32];

   // R1: a reported region that decided an access must be enabled
   a_r1_hit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && fault_kind != 2'd1) |-> sel_cfg[0]);

   a_r4_background: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_kind == 2'd1) |-> (!acc_ok && hit_idx == '0 && prot_on));

   a_r8_off_allows: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_on |-> (acc_ok && fault_kind == 2'd0));

   a_r9_pass_addr: assert property (@(posedge clk) disable iff (!rst_n)
      addr_out == acc_addr);

   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      acc_strobe |=> (flt_valid == !$past(acc_ok)));

   a_r10_report: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_strobe && !acc_ok) |=>
         (flt_region == $past(hit_idx) && flt_code == $past(fault_kind)));

   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_strobe |=> (!flt_valid && flt_code == 2'd0));
endmodule

bind prot_region_check prc_checker #(.NREG(NREG), .AW(AW)) u_prc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .prot_on    (prot_on),
   .acc_strobe (acc_strobe),
   .acc_addr   (acc_addr),
   .rgn_cfg    (rgn_cfg),
   .addr_out   (addr_out),
   .acc_ok     (acc_ok),
   .fault_kind (fault_kind),
   .hit_idx    (hit_idx),
   .flt_valid  (flt_valid),
   .flt_region (flt_region),
   .flt_code   (flt_code)
);

// File: tb/prot_region_check_bench.sv
module prot_region_check_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         prot_on = 1'b0;
   logic         acc_strobe = 1'b0;
   logic [31:0]  acc_addr = '0;
   logic [1:0]   acc_kind = '0;
   logic         acc_priv = 1'b0;
   logic [255:0] rgn_cfg = '0;
   logic [31:0]  perm_data = '0;
   logic [31:0]  perm_inst = '0;
   logic [31:0]  addr_out;
   logic         acc_ok;
   logic [1:0]   fault_kind;
   logic [2:0]   hit_idx;
   logic         flt_valid;
   logic [2:0]   flt_region;
   logic [1:0]   flt_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prot_region_check u_prot_region_check (
      .clk(clk), .rst_n(rst_n), .prot_on(prot_on), .acc_strobe(acc_strobe),
      .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
      .rgn_cfg(rgn_cfg), .perm_data(perm_data), .perm_inst(perm_inst),
      .addr_out(addr_out), .acc_ok(acc_ok), .fault_kind(fault_kind),
      .hit_idx(hit_idx), .flt_valid(flt_valid), .flt_region(flt_region),
      .flt_code(flt_code)
   );

   // descriptor = base | (size << 1) | enable
   function automatic logic [31:0] desc(input logic [31:0] base, input int sz, input bit en);
      return base | (32'(sz) << 1) | 32'(en);
   endfunction

   // Vector: {kind[41:40], priv[39], on[38], addr[37:6], ok[5], fk[4:3], idx[2:0]}
   localparam int NV = 31;
   localparam logic [41:0] VEC [NV] = '{
      {2'd0,1'b0,1'b1,32'h1000_0000,1'b1,2'd0,3'd0}, // R2 whole space
      {2'd1,1'b0,1'b1,32'h1000_0000,1'b1,2'd0,3'd0},
      {2'd2,1'b0,1'b1,32'hFFFF_FFFC,1'b1,2'd0,3'd0}, // R2 top of space
      {2'd1,1'b0,1'b1,32'h2100_0000,1'b0,2'd2,3'd1}, // R6 code 2 user write
      {2'd0,1'b0,1'b1,32'h2100_0000,1'b1,2'd0,3'd1},
      {2'd1,1'b1,1'b1,32'h2100_0000,1'b1,2'd0,3'd1},
      {2'd2,1'b0,1'b1,32'h2100_0000,1'b0,2'd2,3'd1}, // R5 fetch word code 5
      {2'd2,1'b1,1'b1,32'h2100_0000,1'b1,2'd0,3'd1},
      {2'd0,1'b0,1'b1,32'h2400_0010,1'b0,2'd2,3'd2}, // R6 code 1 user
      {2'd1,1'b1,1'b1,32'h2400_0010,1'b1,2'd0,3'd2},
      {2'd2,1'b1,1'b1,32'h2400_0010,1'b0,2'd2,3'd2}, // R6 code 0
      {2'd1,1'b0,1'b1,32'h2400_0880,1'b0,2'd2,3'd7}, // R3 r7 over r2
      {2'd0,1'b0,1'b1,32'h2400_0800,1'b1,2'd0,3'd7}, // R1 first byte
      {2'd2,1'b0,1'b1,32'h2400_08FF,1'b1,2'd0,3'd7}, // R1 last byte
      {2'd0,1'b0,1'b1,32'h2400_0900,1'b0,2'd2,3'd2}, // R1 one past
      {2'd0,1'b1,1'b1,32'h2400_07FF,1'b1,2'd0,3'd2},
      {2'd0,1'b0,1'b1,32'h2400_1000,1'b1,2'd0,3'd1}, // R1 past r2
      {2'd1,1'b0,1'b1,32'h4000_0000,1'b1,2'd0,3'd0}, // R1 disabled r3
      {2'd0,1'b1,1'b1,32'h8000_0000,1'b1,2'd0,3'd4}, // R6 code 5
      {2'd1,1'b1,1'b1,32'h8000_FFFF,1'b0,2'd2,3'd4},
      {2'd0,1'b0,1'b1,32'h8000_0000,1'b0,2'd2,3'd4},
      {2'd0,1'b0,1'b1,32'h8001_0000,1'b1,2'd0,3'd0}, // R1 one past 64K
      {2'd2,1'b0,1'b1,32'h8000_0004,1'b1,2'd0,3'd4}, // R6 code 6 fetch
      {2'd0,1'b1,1'b1,32'h9000_0000,1'b0,2'd2,3'd5}, // R7 code 7
      {2'd2,1'b0,1'b1,32'h9000_0000,1'b1,2'd0,3'd5},
      {2'd0,1'b1,1'b1,32'hA000_0000,1'b0,2'd2,3'd6}, // R6 code 0
      {2'd2,1'b1,1'b1,32'hA000_0000,1'b0,2'd2,3'd6}, // R7 code 4
      {2'd1,1'b0,1'b0,32'hA000_0000,1'b1,2'd0,3'd0}, // R8 off
      {2'd2,1'b0,1'b0,32'h2400_0010,1'b1,2'd0,3'd0}, // R8 off
      {2'd3,1'b0,1'b1,32'h2100_0000,1'b1,2'd0,3'd1}, // R5 kind 3 data word
      {2'd3,1'b0,1'b1,32'h2400_0880,1'b1,2'd0,3'd7}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] k, input logic p, input logic on, input logic [31:0] a);
      acc_kind = k; acc_priv = p; prot_on = on; acc_addr = a;
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      // Region map
      rgn_cfg[0*32 +: 32] = desc(32'h0000_0000, 31, 1'b1);
      rgn_cfg[1*32 +: 32] = desc(32'h2000_0000, 27, 1'b1);
      rgn_cfg[2*32 +: 32] = desc(32'h2400_0000, 11, 1'b1);
      rgn_cfg[3*32 +: 32] = desc(32'h4000_0000, 15, 1'b0);
      rgn_cfg[4*32 +: 32] = desc(32'h8000_0000, 15, 1'b1);
      rgn_cfg[5*32 +: 32] = desc(32'h9000_0000, 15, 1'b1);
      rgn_cfg[6*32 +: 32] = desc(32'hA000_0000, 15, 1'b1);
      rgn_cfg[7*32 +: 32] = desc(32'h2400_0800, 7, 1'b1);
      perm_data = 32'h6075_3123;
      perm_inst = 32'h3436_0056;

      // R11 reset state
      repeat (2) @(negedge clk);
      chk("R11 flt_valid", 64'(flt_valid), 0);
      chk("R11 flt_region", 64'(flt_region), 0);
      chk("R11 flt_code", 64'(flt_code), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][41:40], VEC[i][39], VEC[i][38], VEC[i][37:6]);
         #2;
         chk($sformatf("R6 vec%0d ok", i), 64'(acc_ok), 64'(VEC[i][5]));
         chk($sformatf("R6 vec%0d kind", i), 64'(fault_kind), 64'(VEC[i][4:3]));
         chk($sformatf("R3 vec%0d idx", i), 64'(hit_idx), 64'(VEC[i][2:0]));
         chk($sformatf("R9 vec%0d addr", i), 64'(addr_out), 64'(VEC[i][37:6]));
      end

      // R4: drop the whole-space region, hit a gap
      @(negedge clk);
      rgn_cfg[0] = 1'b0;
      drive(2'd0, 1'b1, 1'b1, 32'h5000_0000);
      #2;
      chk("R4 ok", 64'(acc_ok), 0);
      chk("R4 kind", 64'(fault_kind), 1);
      chk("R4 idx", 64'(hit_idx), 0);

      // R10: strobed background fault reported next edge
      acc_strobe = 1'b1;
      @(posedge clk); #1;
      chk("R10 valid bg", 64'(flt_valid), 1);
      chk("R10 code bg", 64'(flt_code), 1);
      chk("R10 region bg", 64'(flt_region), 0);

      // R10: strobed permission fault in region 6
      @(negedge clk);
      drive(2'd0, 1'b1, 1'b1, 32'hA000_0010);
      @(posedge clk); #1;
      chk("R10 valid perm", 64'(flt_valid), 1);
      chk("R10 code perm", 64'(flt_code), 2);
      chk("R10 region perm", 64'(flt_region), 6);

      // R10: strobed allowed access gives no report
      @(negedge clk);
      drive(2'd0, 1'b1, 1'b1, 32'h8000_0000);
      @(posedge clk); #1;
      chk("R10 valid ok", 64'(flt_valid), 0);
      chk("R10 region ok", 64'(flt_region), 0);

      // R10: faulting access without strobe gives no report
      @(negedge clk);
      acc_strobe = 1'b0;
      drive(2'd0, 1'b1, 1'b1, 32'hA000_0010);
      @(posedge clk); #1;
      chk("R10 valid unstrobed", 64'(flt_valid), 0);
      chk("R10 code unstrobed", 64'(flt_code), 0);

      // R8 with strobe: enable off means no fault report
      @(negedge clk);
      acc_strobe = 1'b1;
      drive(2'd1, 1'b0, 1'b0, 32'h5000_0000);
      @(posedge clk); #1;
      chk("R8 off no report", 64'(flt_valid), 0);
      @(negedge clk);
      acc_strobe = 1'b0;

      // R2 against R1: size 31 on region 5 overrides region 0..4 everywhere
      rgn_cfg[5*32 +: 32] = desc(32'h1234_5678, 31, 1'b1);
      drive(2'd2, 1'b0, 1'b1, 32'h0000_0000);
      #2;
      chk("R2 size31 idx", 64'(hit_idx), 5);
      chk("R2 size31 ok", 64'(acc_ok), 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule